// File: doc/BRIEF.md
# Frame Length Limit Checker

This block sets the largest frame the MAC accepts in each direction and flags any frame that goes over it. The limit depends on two mode bits in a configuration word and on a jumbo length register that software writes. A hard ceiling fixed at build time bounds that register. Software can write a jumbo length above the ceiling. The block then uses the ceiling instead and keeps a sticky error bit so software can see that the clamp happened.

Each length arrives with a valid strobe, a direction flag and a queue number. A receive length is checked on its own. A transmit length is one fragment of a gathered frame, so the block adds it to a running total and checks the total. The verdict is registered and appears one cycle after the strobe. It comes out as a reject pulse and as a bus-error interrupt pulse on the line for the queue that carried the frame. After a transmit frame is aborted, its remaining fragments are dropped until the last one arrives.

Top module: `frame_len_guard`

## Requirements
- R1: After reset the jumbo length readback equals the hard ceiling (default 10240), the sticky clamp bit is 0, and the reject and interrupt outputs are 0.
- R2: With jumbo mode off (cfg_word bit 3 = 0), the transmit limit is 1518 whatever the value of cfg_word bit 8.
- R3: With jumbo mode off, the receive limit is 1538 when cfg_word bit 8 is 1 and 1518 when it is 0.
- R4: With jumbo mode on (cfg_word bit 3 = 1), both limits equal the jumbo length register. When the register holds a value above the hard ceiling, both limits equal the ceiling.
- R5: A jumbo length write keeps only the low JW bits of the data (default 14, mask 0x3FFF). The readback returns the stored value.
- R6: A jumbo length write whose stored value exceeds the ceiling sets cfg_err. cfg_err stays set until a clear write with err_wdata = 1. A clear write with err_wdata = 0 has no effect, and a clamp in the same cycle as a clear leaves the bit set.
- R7: A receive length above the receive limit gives a one-cycle reject pulse in the cycle after the strobe. A length equal to the limit gives no pulse.
- R8: Every reject also pulses bus_err_irq[q] in the same cycle, where q is the queue that came with the strobe. All other lines stay low, and no line pulses without a reject.
- R9: Transmit fragments add up into a running total, and len_last marks the final fragment. The fragment that lifts the total above the transmit limit causes a reject, even if every earlier fragment was accepted. A frame whose total equals the limit is accepted.
- R10: After a transmit abort, fragments of the same frame cause no reject, and this holds up to and including the one with len_last. The next frame's total starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 16 | Mode bits: bit 3 jumbo enable, bit 8 long receive |
| jlen_wr | input | 1 | Jumbo length write strobe |
| jlen_wdata | input | LEN_W | Jumbo length write data |
| jlen_rdata | output | LEN_W | Stored jumbo length readback |
| err_wr | input | 1 | Clamp status clear write strobe |
| err_wdata | input | 1 | Write 1 to clear the clamp status |
| cfg_err | output | 1 | Sticky jumbo clamp status |
| len_valid | input | 1 | Length strobe |
| len_tx | input | 1 | 1 = transmit fragment, 0 = receive frame |
| len_last | input | 1 | Last fragment of a transmit frame |
| len_q | input | QW | Queue carrying the frame |
| len_value | input | LEN_W | Frame or fragment length in bytes |
| lim_tx | output | LEN_W | Effective transmit limit |
| lim_rx | output | LEN_W | Effective receive limit |
| reject | output | 1 | Over-length pulse |
| bus_err_irq | output | NQ | Per-queue bus-error interrupt pulse |

## Verification
The bench tests lengths exactly at each limit and one byte past it, in all three mode settings. An off-by-one comparison would reject a legal 1518 or 1538 frame, or would let 1519 through. It writes a jumbo length wider than the field and one above the ceiling. Missing masking would show up in the readback, and a missing clamp would let the limit climb past 10240 with no cfg_err. Transmit frames are split so that no fragment is too long on its own but the total is. A design that checked fragments one at a time would pass them. A design that kept checking after an abort would raise extra rejects, or would carry the old total into the next frame.

// File: rtl/frame_len_guard.sv
module frame_len_guard #(
  parameter int LEN_W     = 16,
  parameter int JW        = 14,
  parameter int HARD_CEIL = 10240,
  parameter int NQ        = 4,
  localparam int QW       = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      cfg_word,
  input  logic             jlen_wr,
  input  logic [LEN_W-1:0] jlen_wdata,
  output logic [LEN_W-1:0] jlen_rdata,
  input  logic             err_wr,
  input  logic             err_wdata,
  output logic             cfg_err,
  input  logic             len_valid,
  input  logic             len_tx,
  input  logic             len_last,
  input  logic [QW-1:0]    len_q,
  input  logic [LEN_W-1:0] len_value,
  output logic [LEN_W-1:0] lim_tx,
  output logic [LEN_W-1:0] lim_rx,
  output logic             reject,
  output logic [NQ-1:0]    bus_err_irq
);
  localparam logic [LEN_W-1:0] CEIL    = LEN_W'(HARD_CEIL);
  localparam logic [LEN_W-1:0] STD_LEN = LEN_W'(1518);
  localparam logic [LEN_W-1:0] LONG_RX = LEN_W'(1538);

  logic [JW-1:0]    jlen_q;
  logic [LEN_W-1:0] jlen_ext, jumbo_eff, tx_acc;
  logic             tx_skip;
  logic [LEN_W:0]   tx_sum;
  logic             wr_over, tx_over, rx_over, hit;

  wire jumbo_on = cfg_word[3];
  wire rx_long  = cfg_word[8];

  assign jlen_ext   = LEN_W'(jlen_q);
  assign jlen_rdata = jlen_ext;
  assign jumbo_eff  = (jlen_ext > CEIL) ? CEIL : jlen_ext;
  assign lim_tx     = jumbo_on ? jumbo_eff : STD_LEN;
  assign lim_rx     = jumbo_on ? jumbo_eff : (rx_long ? LONG_RX : STD_LEN);

  assign wr_over = jlen_wr && (LEN_W'(jlen_wdata[JW-1:0]) > CEIL);
  assign tx_sum  = {1'b0, tx_acc} + {1'b0, len_value};
  assign tx_over = tx_sum > {1'b0, lim_tx};
  assign rx_over = len_value > lim_rx;
  assign hit     = len_valid && (len_tx ? (!tx_skip && tx_over) : rx_over);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      jlen_q  <= JW'(HARD_CEIL);
      cfg_err <= 1'b0;
    end else begin
      if (jlen_wr) jlen_q <= jlen_wdata[JW-1:0];
      if (wr_over) cfg_err <= 1'b1;
      else if (err_wr && err_wdata) cfg_err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_acc  <= '0;
      tx_skip <= 1'b0;
    end else if (len_valid && len_tx) begin
      if (tx_skip) begin
        if (len_last) tx_skip <= 1'b0;
      end else if (tx_over) begin
        tx_acc  <= '0;
        tx_skip <= !len_last;
      end else begin
        tx_acc <= len_last ? '0 : tx_sum[LEN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reject      <= 1'b0;
      bus_err_irq <= '0;
    end else begin
      reject      <= hit;
      bus_err_irq <= '0;
      if (hit) bus_err_irq[len_q] <= 1'b1;
    end
  end

  a_r4_limit_within_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    jumbo_on |-> (lim_tx <= CEIL && lim_rx <= CEIL));
  a_r2_std_tx_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !jumbo_on |-> lim_tx == STD_LEN);
  a_r6_clamp_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    wr_over |=> cfg_err);
  a_r7_reject_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> $past(len_valid));
  a_r8_irq_with_reject: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_err_irq) && ((|bus_err_irq) == reject));
  a_r10_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (len_valid && len_tx && tx_skip) |=> !reject);
endmodule

// File: tb/tb_frame_len_guard.sv
module tb_frame_len_guard;
  localparam int LEN_W = 16;
  localparam int NQ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_word = '0;
  logic jlen_wr = 1'b0;
  logic [LEN_W-1:0] jlen_wdata = '0;
  logic [LEN_W-1:0] jlen_rdata;
  logic err_wr = 1'b0, err_wdata = 1'b0, cfg_err;
  logic len_valid = 1'b0, len_tx = 1'b0, len_last = 1'b0;
  logic [1:0] len_q = '0;
  logic [LEN_W-1:0] len_value = '0;
  logic [LEN_W-1:0] lim_tx, lim_rx;
  logic reject;
  logic [NQ-1:0] bus_err_irq;

  int checks = 0, fails = 0;

  frame_len_guard dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .jlen_wr(jlen_wr), .jlen_wdata(jlen_wdata), .jlen_rdata(jlen_rdata),
    .err_wr(err_wr), .err_wdata(err_wdata), .cfg_err(cfg_err),
    .len_valid(len_valid), .len_tx(len_tx), .len_last(len_last),
    .len_q(len_q), .len_value(len_value),
    .lim_tx(lim_tx), .lim_rx(lim_rx), .reject(reject), .bus_err_irq(bus_err_irq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_jlen(input int v);
    @(negedge clk); jlen_wr = 1'b1; jlen_wdata = LEN_W'(v);
    @(negedge clk); jlen_wr = 1'b0;
  endtask

  task automatic clear_err(input logic d);
    @(negedge clk); err_wr = 1'b1; err_wdata = d;
    @(negedge clk); err_wr = 1'b0;
  endtask

  task automatic send(input string req, input logic tx, input logic last,
                      input int q, input int len, input logic exp_rej);
    @(negedge clk);
    len_valid = 1'b1; len_tx = tx; len_last = last; len_q = 2'(q); len_value = LEN_W'(len);
    @(negedge clk);
    len_valid = 1'b0;
    chk(req, int'(reject), int'(exp_rej));
    chk(req, int'(bus_err_irq), exp_rej ? (1 << q) : 0);
    @(negedge clk);
    chk(req, int'(reject), 0);
  endtask

  task automatic t_reset;
    chk("R1", int'(jlen_rdata), 10240);
    chk("R1", int'(cfg_err), 0);
    chk("R1", int'(reject), 0);
    chk("R1", int'(bus_err_irq), 0);
  endtask

  task automatic t_std_limits;
    @(negedge clk); cfg_word = 16'h0000;
    #1 chk("R2", int'(lim_tx), 1518); chk("R3", int'(lim_rx), 1518);
    cfg_word = 16'h0100;
    #1 chk("R2", int'(lim_tx), 1518); chk("R3", int'(lim_rx), 1538);
  endtask

  task automatic t_jumbo_reg;
    write_jlen(9000);
    cfg_word = 16'h0108;
    #1 chk("R4", int'(lim_tx), 9000); chk("R4", int'(lim_rx), 9000);
    chk("R5", int'(jlen_rdata), 9000);
    chk("R6", int'(cfg_err), 0);
    write_jlen(16'hFFFF);
    chk("R5", int'(jlen_rdata), 16'h3FFF);
    chk("R6", int'(cfg_err), 1);
    chk("R4", int'(lim_tx), 10240); chk("R4", int'(lim_rx), 10240);
    clear_err(1'b0);
    chk("R6", int'(cfg_err), 1);
    @(negedge clk); err_wr = 1'b1; err_wdata = 1'b1; jlen_wr = 1'b1; jlen_wdata = 16'd12000;
    @(negedge clk); err_wr = 1'b0; jlen_wr = 1'b0;
    chk("R6", int'(cfg_err), 1);
    clear_err(1'b1);
    chk("R6", int'(cfg_err), 0);
    write_jlen(4000);
    chk("R4", int'(lim_rx), 4000);
    send("R4", 1'b0, 1'b0, 0, 4001, 1'b1);
    send("R4", 1'b0, 1'b0, 0, 4000, 1'b0);
  endtask

  task automatic t_rx;
    @(negedge clk); cfg_word = 16'h0000;
    send("R7", 1'b0, 1'b0, 0, 1518, 1'b0);
    send("R7", 1'b0, 1'b0, 1, 1519, 1'b1);
    @(negedge clk); cfg_word = 16'h0100;
    send("R7", 1'b0, 1'b0, 3, 1538, 1'b0);
    send("R8", 1'b0, 1'b0, 2, 1539, 1'b1);
    send("R8", 1'b0, 1'b0, 3, 2000, 1'b1);
  endtask

  task automatic t_tx;
    @(negedge clk); cfg_word = 16'h0100;
    send("R9", 1'b1, 1'b0, 0, 1000, 1'b0);
    send("R9", 1'b1, 1'b1, 0, 518, 1'b0);
    send("R9", 1'b1, 1'b0, 1, 1000, 1'b0);
    send("R9", 1'b1, 1'b0, 1, 519, 1'b1);
    send("R10", 1'b1, 1'b0, 1, 1500, 1'b0);
    send("R10", 1'b1, 1'b1, 1, 1500, 1'b0);
    send("R10", 1'b1, 1'b0, 0, 1500, 1'b0);
    send("R10", 1'b1, 1'b1, 0, 18, 1'b0);
    send("R9", 1'b1, 1'b1, 2, 1519, 1'b1);
    send("R10", 1'b1, 1'b1, 0, 1518, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_std_limits();
        t_rx();
        t_tx();
        t_jumbo_reg();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule